// File: doc/BRIEF.md
# HDLC Event Interrupt Queue Writer

This block gathers transmit and receive events from a bank of HDLC DMA channels and stores each one as a 16-bit status word in a circular interrupt queue in shared memory. Every queue slot works as a mailbox. Its top bit is an ownership flag: the writer sets it when it posts a word, and the host clears it after it has read the word.

Each channel has one transmit source and one receive source. A source raises its request with five event flags and an interrupt-enable bit taken from its descriptor. The writer picks one request, acknowledges it and packs the status word. It then reads the slot at the write pointer. If the host has released the slot, the writer writes the word there and advances the pointer. If the host still owns the slot, the writer drops the event and sets a sticky overflow flag. The host clears that flag by writing 1 to it.

Top module: `hdlc_irq_queue_writer`

## Requirements
- R1: Status word fields: bit 15 = new-status flag, bit 14 = channel group, bit 13 = direction (1 transmit, 0 receive), bits 12..8 = channel number within the group, bits 7..5 = 0, bits 4..0 = event flags. The flag bits are: bit 4 frame-done, bit 3 buffer (emptied or filled), bit 2 halted, bit 1 end-of-queue, bit 0 repeat-last-frame (transmit) or receive-error (receive).
- R2: Source index s serves channel s/2. An even s is transmit and an odd s is receive. Channels 32..63 put 1 in bit 14, channels 0..31 put 0 there, and bits 12..8 carry the channel number modulo 32.
- R3: With the source's interrupt-enable input at 0, a transmit word has bits 4 and 3 forced to 0, and a receive word has only bit 3 forced to 0. With the enable at 1, all five flags pass through unchanged.
- R4: For each event the writer first reads the slot at queue base plus write pointer. If bit 15 of that slot is 0, it writes the status word with bit 15 = 1 to the same address.
- R5: If the slot read back has bit 15 = 1, the writer does not write, drops the event (it is still acknowledged), sets the overflow output and leaves the write pointer unchanged.
- R6: The overflow output stays at 1 until the clear input is pulsed. The clear has no effect in a cycle where a new overflow is detected.
- R7: The write pointer starts at 0 and advances by one after each successful write. After the write to slot size-1 it wraps to 0. The slot count comes from the queue-size input.
- R8: When several requests are pending, the writer serves the lowest source index first, so a lower channel comes before a higher one and transmit comes before receive on the same channel. At most one acknowledge is high per cycle, and the writer handles one event at a time.
- R9: After reset there is no memory request, no acknowledge, the overflow output is 0 and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_req_i | input | 2*N_CH | Event request per source (even index transmit, odd index receive) |
| evt_flags_i | input | 5*2*N_CH | Five event flags per source, source s at bits 5s+4..5s |
| evt_int_en_i | input | 2*N_CH | Descriptor interrupt-enable per source |
| evt_ack_o | output | 2*N_CH | One-hot acknowledge; the source drops its request afterwards |
| q_base_i | input | AW | Word address of queue slot 0 |
| q_size_i | input | QW | Number of slots in the queue |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata_i | input | 16 | Read data |
| icov_clr_i | input | 1 | Write-1 pulse that clears the overflow flag |
| icov_o | output | 1 | Sticky queue-overflow interrupt flag |

## Verification
Single events are posted from a low transmit channel, a high receive channel and a high transmit channel, with the enable set and cleared. These separate the group bit, the channel field, the direction bit and the direction-dependent flag masking. Releasing only some slots before posting shows the difference between a wrap to slot 0, an overflow that leaves memory and pointer unchanged, and a retry that lands in the slot that was skipped. Three requests raised in the same cycle from two channels show that the order follows the channel number first and the direction second, not the order in which the requests were raised.

// File: rtl/hq_pkg.sv
package hq_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned CH_W   = 6;  // group bit + 5-bit channel field

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WRITE = 2'd2
  } wr_state_e;
endpackage

// File: rtl/hq_arb.sv
module hq_arb #(
  parameter int unsigned N  = 128,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |req_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gnt_o[g] = any_o && (idx_o == IW'(g));
  end

  // R8
  gnt_onehot_chk: assert final ($onehot0(gnt_o));
endmodule

// File: rtl/hq_pack.sv
module hq_pack
  import hq_pkg::*;
(
  input  logic [CH_W-1:0]   ch_i,
  input  logic              tx_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              int_en_i,
  output logic [WORD_W-1:0] word_o
);
  logic [FLAG_W-1:0] fl;

  always_comb begin
    fl = flags_i;
    if (!int_en_i) begin
      fl[3] = 1'b0;
      if (tx_i) fl[4] = 1'b0;
    end
    word_o = {1'b1, ch_i[CH_W-1], tx_i, ch_i[CH_W-2:0], 3'b000, fl};
  end
endmodule

// File: rtl/hq_ptr.sv
module hq_ptr #(
  parameter int unsigned QW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [QW-1:0] size_i,
  output logic [QW-1:0] ptr_o
);
  logic last;
  assign last = (size_i == '0) || (ptr_o >= size_i - QW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= last ? '0 : ptr_o + QW'(1);
  end

  // R7
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && last) |=> (ptr_o == '0));
  // R7
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));
endmodule

// File: rtl/hdlc_irq_queue_writer.sv
module hdlc_irq_queue_writer
  import hq_pkg::*;
#(
  parameter int unsigned N_CH = 64,
  parameter int unsigned AW   = 16,
  parameter int unsigned QW   = 8,
  localparam int unsigned NSRC = 2 * N_CH,
  localparam int unsigned IW   = $clog2(NSRC)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NSRC-1:0]        evt_req_i,
  input  logic [NSRC*FLAG_W-1:0] evt_flags_i,
  input  logic [NSRC-1:0]        evt_int_en_i,
  output logic [NSRC-1:0]        evt_ack_o,
  input  logic [AW-1:0]          q_base_i,
  input  logic [QW-1:0]          q_size_i,
  output logic                   mem_req_o,
  output logic                   mem_we_o,
  output logic [AW-1:0]          mem_addr_o,
  output logic [WORD_W-1:0]      mem_wdata_o,
  input  logic                   mem_ack_i,
  input  logic [WORD_W-1:0]      mem_rdata_i,
  input  logic                   icov_clr_i,
  output logic                   icov_o
);
  wr_state_e         state;
  logic [NSRC-1:0]   gnt;
  logic [IW-1:0]     win_idx, cap_idx;
  logic              any_req;
  logic [FLAG_W-1:0] cap_flags;
  logic              cap_en;
  logic [CH_W-1:0]   cap_ch;
  logic [QW-1:0]     wr_ptr;
  logic              adv, ovf;
  logic [WORD_W-1:0] word;

  hq_arb #(.N(NSRC)) u_arb (
    .req_i (evt_req_i),
    .gnt_o (gnt),
    .idx_o (win_idx),
    .any_o (any_req)
  );

  assign cap_ch = CH_W'(cap_idx[IW-1:1]);

  hq_pack u_pack (
    .ch_i     (cap_ch),
    .tx_i     (~cap_idx[0]),
    .flags_i  (cap_flags),
    .int_en_i (cap_en),
    .word_o   (word)
  );

  hq_ptr #(.QW(QW)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .size_i (q_size_i),
    .ptr_o  (wr_ptr)
  );

  assign evt_ack_o   = (state == ST_IDLE) ? gnt : '0;
  assign mem_req_o   = (state != ST_IDLE);
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_addr_o  = q_base_i + AW'(wr_ptr);
  assign mem_wdata_o = word;
  assign adv         = (state == ST_WRITE) && mem_ack_i;
  assign ovf         = (state == ST_READ) && mem_ack_i && mem_rdata_i[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state     <= ST_IDLE;
      cap_idx   <= '0;
      cap_flags <= '0;
      cap_en    <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (any_req) begin
          cap_idx   <= win_idx;
          cap_flags <= evt_flags_i[win_idx*FLAG_W +: FLAG_W];
          cap_en    <= evt_int_en_i[win_idx];
          state     <= ST_READ;
        end
        ST_READ: if (mem_ack_i) state <= mem_rdata_i[WORD_W-1] ? ST_IDLE : ST_WRITE;
        ST_WRITE: if (mem_ack_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // new overflow wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         icov_o <= 1'b0;
    else if (ovf)        icov_o <= 1'b1;
    else if (icov_clr_i) icov_o <= 1'b0;
  end

  // R5
  ovf_sets_icov_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf |=> (icov_o && state == ST_IDLE && $stable(wr_ptr)));
  // R6
  icov_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icov_o && !icov_clr_i) |=> icov_o);
  // R4
  write_after_free_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_o) |-> ($past(state) == ST_READ && !$past(mem_rdata_i[WORD_W-1])));
  // R8
  ack_only_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o |-> evt_ack_o == '0));
  // R4
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> $stable(mem_addr_o));
endmodule

// File: tb/tb_hdlc_irq_queue_writer.sv
module tb_hdlc_irq_queue_writer;
  localparam int N_CH = 64;
  localparam int NSRC = 2 * N_CH;
  localparam int AW = 16;
  localparam int QW = 8;
  localparam int BASE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0]   req = '0;
  logic [NSRC*5-1:0] flags = '0;
  logic [NSRC-1:0]   ens = '0;
  logic [NSRC-1:0]   ack;
  logic [AW-1:0]     q_base = AW'(BASE);
  logic [QW-1:0]     q_size = QW'(3);
  logic              mem_req, mem_we, mem_ack;
  logic [AW-1:0]     mem_addr;
  logic [15:0]       mem_wdata, mem_rdata;
  logic              icov_clr = 1'b0;
  logic              icov;

  logic [15:0] mem [256];
  logic [15:0] log_addr [32];
  logic [15:0] log_data [32];
  int log_n = 0;
  int errs = 0;
  int checks = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  hdlc_irq_queue_writer #(.N_CH(N_CH), .AW(AW), .QW(QW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .evt_req_i(req), .evt_flags_i(flags), .evt_int_en_i(ens), .evt_ack_o(ack),
    .q_base_i(q_base), .q_size_i(q_size),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .icov_clr_i(icov_clr), .icov_o(icov)
  );

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    req <= req & ~ack;
    if (mem_req && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      if (log_n < 32) begin
        log_addr[log_n] <= mem_addr;
        log_data[log_n] <= mem_wdata;
      end
      log_n <= log_n + 1;
    end
  end

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(int ch, bit tx, logic [4:0] fl, bit en);
    logic [4:0] f = fl;
    logic [5:0] c = 6'(ch);
    if (!en) begin
      f[3] = 1'b0;
      if (tx) f[4] = 1'b0;
    end
    return {1'b1, c[5], tx, c[4:0], 3'b000, f};
  endfunction

  task automatic post(int src, logic [4:0] fl, bit en);
    @(negedge clk);
    flags[src*5 +: 5] = fl;
    ens[src] = en;
    req[src] = 1'b1;
    repeat (50) begin
      @(negedge clk);
      if (!req[src]) break;
    end
    chk("R8 ack seen", 32'(req[src]), 0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 mem_req", 32'(mem_req), 0);
    chk("R9 ack", 32'(ack), 0);
    chk("R9 icov", 32'(icov), 0);
  endtask

  task automatic t_tx_basic();
    post(6, 5'b11111, 1);  // ch3 transmit
    chk("R4 addr", 32'(log_addr[0]), BASE);
    chk("R1 word", 32'(log_data[0]), 32'(exp_word(3, 1, 5'b11111, 1)));
    chk("R1 literal", 32'(log_data[0]), 32'h0000A31F);
    chk("R4 mem", 32'(mem[BASE]), 32'h0000A31F);
  endtask

  task automatic t_rx_masked();
    post(81, 5'b11111, 0);  // ch40 receive, enable off
    chk("R7 addr", 32'(log_addr[1]), BASE + 1);
    chk("R3 rx word", 32'(log_data[1]), 32'(exp_word(40, 0, 5'b11111, 0)));
    chk("R2 group bit", 32'(log_data[1][14]), 1);
    chk("R2 channel field", 32'(log_data[1][12:8]), 8);
    chk("R2 direction", 32'(log_data[1][13]), 0);
  endtask

  task automatic t_tx_masked();
    post(66, 5'b11111, 0);  // ch33 transmit, enable off
    chk("R7 addr", 32'(log_addr[2]), BASE + 2);
    chk("R3 tx flags", 32'(log_data[2][4:0]), 32'h07);
    chk("R2 tx word", 32'(log_data[2]), 32'(exp_word(33, 1, 5'b11111, 0)));
  endtask

  task automatic t_wrap();
    @(negedge clk); mem[BASE] = 16'h0000;
    post(0, 5'b00010, 1);
    chk("R7 wrap addr", 32'(log_addr[3]), BASE);
    chk("R7 wrap word", 32'(log_data[3]), 32'(exp_word(0, 1, 5'b00010, 1)));
  endtask

  task automatic t_overflow();
    post(2, 5'b00001, 1);  // slot 1 still owned
    chk("R5 no write", 32'(log_n), 4);
    chk("R5 slot kept", 32'(mem[BASE+1]), 32'(exp_word(40, 0, 5'b11111, 0)));
    chk("R5 icov", 32'(icov), 1);
  endtask

  task automatic t_icov_clear();
    repeat (5) @(negedge clk);
    chk("R6 sticky", 32'(icov), 1);
    icov_clr = 1'b1;
    @(negedge clk);
    icov_clr = 1'b0;
    chk("R6 cleared", 32'(icov), 0);
  endtask

  task automatic t_retry_same_slot();
    @(negedge clk); mem[BASE+1] = 16'h0000;
    post(4, 5'b00100, 1);
    chk("R5 ptr held", 32'(log_addr[4]), BASE + 1);
    chk("R5 retry word", 32'(log_data[4]), 32'(exp_word(2, 1, 5'b00100, 1)));
  endtask

  task automatic t_priority();
    @(negedge clk);
    for (int i = 0; i < 3; i++) mem[BASE+i] = 16'h0000;
    flags[10*5 +: 5] = 5'b00001; ens[10] = 1'b1;
    flags[5*5 +: 5]  = 5'b00010; ens[5]  = 1'b1;
    flags[4*5 +: 5]  = 5'b00100; ens[4]  = 1'b1;
    req[10] = 1'b1; req[5] = 1'b1; req[4] = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 all served", 32'(log_n), 8);
    chk("R8 first", 32'(log_data[5]), 32'(exp_word(2, 1, 5'b00100, 1)));
    chk("R8 second", 32'(log_data[6]), 32'(exp_word(2, 0, 5'b00010, 1)));
    chk("R8 third", 32'(log_data[7]), 32'(exp_word(5, 1, 5'b00001, 1)));
    chk("R7 order addr", 32'(log_addr[6]), BASE);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_tx_basic();
    t_rx_masked();
    t_tx_masked();
    t_wrap();
    t_overflow();
    t_icov_clear();
    t_retry_same_slot();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule